// File: doc/BRIEF.md
# Decimal Complement Subtractor

This block subtracts one unsigned packed-BCD word from another in pure combinational logic, without ever performing a binary subtraction. Every digit of the subtrahend passes through a small lookup that returns its nines partner, the digit that brings it up to nine. The resulting word is then added to the minuend through a ripple chain of decimal digit adders. The carry into the lowest digit is tied to one, which turns the nines complement into the ten's complement.

The carry leaving the top digit is not part of the result. It is brought out as a no-borrow flag: it is one exactly when the minuend is at least the subtrahend. In that case the digits hold the true difference. Otherwise the digits hold the ten's complement of the true shortfall. The digit count is a parameter, and the block is intended to be instantiated wherever decimal counters, meters or accumulators need a compare-and-subtract step.

Top module: `bcd_tens_sub`

## Requirements
- R1: For operands whose digits are all in 0..9, every four-bit digit of the result lies in 0..9. Digit k occupies bits 4k+3 down to 4k, and digit 0 is the least significant.
- R2: When the minuend X is greater than or equal to the subtrahend Y, `no_borrow` is 1 and `diff_bcd` encodes X - Y.
- R3: When X < Y, `no_borrow` is 0 and `diff_bcd` encodes 10^N - (Y - X). For example, 3 - 4 with three digits gives 999.
- R4: Equal operands give a result of all zero digits with `no_borrow` at 1.
- R5: A zero subtrahend returns the minuend unchanged with `no_borrow` at 1. This holds because the injected one ripples through a word of all-nine digits.
- R6: Each subtrahend digit d is replaced by its nines partner 9 - d before the addition, so a digit and its partner always sum to nine.
- R7: The carry into the least significant digit adder is constantly 1, and the carry between digits propagates from digit k into digit k+1.
- R8: Worked cases on three digits: 741 - 258 gives 483, 025 - 018 gives 007 and 005 - 003 gives 002, each with `no_borrow` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_bcd | input | 4*DIGITS | Minuend, packed BCD, digit 0 in the low nibble |
| y_bcd | input | 4*DIGITS | Subtrahend, packed BCD, digit 0 in the low nibble |
| diff_bcd | output | 4*DIGITS | Difference, or ten's complement of the shortfall when X < Y |
| no_borrow | output | 1 | Decimal carry out of the top digit; 1 when X >= Y |

## Verification
A wrong nines partner for any digit value shifts the result by a fixed decimal amount. That error appears on `diff_bcd` in the same evaluation as the operands that use that digit. A missing decimal correction or a broken carry link shows up as a non-decimal nibble, or as an off-by-power-of-ten result, wherever that digit position overflows. A wrong carry seed or a wrong top carry flips `no_borrow` against the operand order at once. The exhaustive two-digit sweep reaches every digit pairing and every carry pattern, so each of these faults surfaces on the first affected operand pair.

// File: rtl/bcd_sub_pkg.sv
package bcd_sub_pkg;

  typedef logic [3:0] digit_t;

  typedef struct packed {
    logic   carry;
    digit_t digit;
  } dsum_t;

  // Nines partner by lookup, no subtract operation.
  function automatic digit_t nines_partner(input digit_t d);
    digit_t r;
    case (d)
      4'd0: r = 4'd9;
      4'd1: r = 4'd8;
      4'd2: r = 4'd7;
      4'd3: r = 4'd6;
      4'd4: r = 4'd5;
      4'd5: r = 4'd4;
      4'd6: r = 4'd3;
      4'd7: r = 4'd2;
      4'd8: r = 4'd1;
      4'd9: r = 4'd0;
      default: r = 4'd0;
    endcase
    return r;
  endfunction

  // One decimal digit addition with carry; six is added past nine.
  function automatic dsum_t decimal_add(input digit_t a, input digit_t b,
                                        input logic cin);
    logic [4:0] raw;
    logic [4:0] fixed;
    dsum_t      r;
    raw = {1'b0, a} + {1'b0, b} + {4'b0000, cin};
    if (raw > 5'd9) begin
      fixed   = raw + 5'd6;
      r.carry = 1'b1;
      r.digit = fixed[3:0];
    end else begin
      r.carry = 1'b0;
      r.digit = raw[3:0];
    end
    return r;
  endfunction

endpackage

// File: rtl/bcd_nines_map.sv
module bcd_nines_map
  import bcd_sub_pkg::*;
(
  input  logic [3:0] digit_in,
  output logic [3:0] partner_out
);
  always_comb partner_out = nines_partner(digit_in);
endmodule

// File: rtl/bcd_digit_adder.sv
module bcd_digit_adder
  import bcd_sub_pkg::*;
(
  input  logic [3:0] a_dig,
  input  logic [3:0] b_dig,
  input  logic       c_in,
  output logic [3:0] s_dig,
  output logic       c_out
);
  dsum_t res;
  always_comb begin
    res   = decimal_add(a_dig, b_dig, c_in);
    s_dig = res.digit;
    c_out = res.carry;
  end
endmodule

// File: rtl/bcd_tens_sub.sv
module bcd_tens_sub #(
  parameter int DIGITS = 3
) (
  input  logic [4*DIGITS-1:0] x_bcd,
  input  logic [4*DIGITS-1:0] y_bcd,
  output logic [4*DIGITS-1:0] diff_bcd,
  output logic                no_borrow
);
  localparam int W = 4 * DIGITS;

  logic [W-1:0]    y_partner;   // nines partner word
  logic [DIGITS:0] dig_carry;   // carry chain, index 0 is the seed

  assign dig_carry[0] = 1'b1;

  for (genvar k = 0; k < DIGITS; k++) begin : g_digit
    bcd_nines_map u_map (
      .digit_in    (y_bcd[4*k +: 4]),
      .partner_out (y_partner[4*k +: 4])
    );
    bcd_digit_adder u_add (
      .a_dig (x_bcd[4*k +: 4]),
      .b_dig (y_partner[4*k +: 4]),
      .c_in  (dig_carry[k]),
      .s_dig (diff_bcd[4*k +: 4]),
      .c_out (dig_carry[k+1])
    );
  end

  assign no_borrow = dig_carry[DIGITS];
endmodule

// File: rtl/bcd_tens_sub_chk.sv
module bcd_tens_sub_chk #(
  parameter int DIGITS = 3
) (
  input logic [4*DIGITS-1:0] x_bcd,
  input logic [4*DIGITS-1:0] y_bcd,
  input logic [4*DIGITS-1:0] diff_bcd,
  input logic                no_borrow,
  input logic [4*DIGITS-1:0] y_partner,
  input logic [DIGITS:0]     dig_carry
);
  function automatic logic all_decimal(input logic [4*DIGITS-1:0] w);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < DIGITS; k++)
      if (w[4*k +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  logic inputs_ok;
  always_comb inputs_ok = !$isunknown({x_bcd, y_bcd}) && all_decimal(x_bcd)
                          && all_decimal(y_bcd);

  always_comb begin
    if (inputs_ok) begin
      assert_digit_valid_R1: assert (all_decimal(diff_bcd))
        else $error("R1 result digit out of decimal range");
      // packed BCD order matches numeric order, so a plain compare decides
      assert_ge_flag_R2: assert (no_borrow == (x_bcd >= y_bcd))
        else $error("R2/R3 no_borrow disagrees with operand order");
      if (x_bcd == y_bcd) begin
        assert_equal_zero_R4: assert (diff_bcd == '0 && no_borrow)
          else $error("R4 equal operands not giving zero");
      end
      if (y_bcd == '0) begin
        assert_zero_sub_R5: assert (diff_bcd == x_bcd)
          else $error("R5 zero subtrahend altered minuend");
      end
      for (int k = 0; k < DIGITS; k++) begin
        assert_nines_pair_R6: assert ({1'b0, y_bcd[4*k +: 4]} + {1'b0, y_partner[4*k +: 4]} == 5'd9)
          else $error("R6 nines partner wrong");
      end
      assert_carry_seed_R7: assert (dig_carry[0] == 1'b1 && dig_carry[DIGITS] == no_borrow)
        else $error("R7 carry seed or top carry wrong");
    end
  end
endmodule

bind bcd_tens_sub bcd_tens_sub_chk #(.DIGITS(DIGITS)) u_chk (
  .x_bcd     (x_bcd),
  .y_bcd     (y_bcd),
  .diff_bcd  (diff_bcd),
  .no_borrow (no_borrow),
  .y_partner (y_partner),
  .dig_carry (dig_carry)
);

// File: tb/bcd_tens_sub_tb.sv
module bcd_tens_sub_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;  // 200 MHz

  int n_checks = 0;
  int n_fail   = 0;
  logic done = 1'b0;

  // three-digit instance (default parameter)
  logic [11:0] x3 = '0, y3 = '0, d3;
  logic        nb3;
  bcd_tens_sub u_dut (.x_bcd(x3), .y_bcd(y3), .diff_bcd(d3), .no_borrow(nb3));

  // two-digit instance for the exhaustive sweep
  logic [7:0] x2 = '0, y2 = '0, d2;
  logic       nb2;
  bcd_tens_sub #(.DIGITS(2)) u_dut2 (.x_bcd(x2), .y_bcd(y2), .diff_bcd(d2), .no_borrow(nb2));

  function automatic logic [15:0] to_bcd(input int v);
    logic [15:0] r;
    int t;
    t = v;
    r = '0;
    for (int k = 0; k < 4; k++) begin
      r[4*k +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] got_d,
                       input logic [15:0] exp_d, input logic got_nb,
                       input logic exp_nb);
    n_checks++;
    if (got_d !== exp_d || got_nb !== exp_nb) begin
      n_fail++;
      $display("FAIL %s: got diff=%h nb=%b expected diff=%h nb=%b",
               req, got_d, got_nb, exp_d, exp_nb);
    end
  endtask

  task automatic apply3(input int a, input int b);
    @(negedge clk);
    x3 = to_bcd(a)[11:0];
    y3 = to_bcd(b)[11:0];
    #1;
  endtask

  task automatic t_start_state;
    #1;
    check("R4 start zero", {4'h0, d3}, 16'h0000, nb3, 1'b1);
  endtask

  task automatic t_worked_cases;
    apply3(741, 258); check("R8 741-258", {4'h0, d3}, 16'h0483, nb3, 1'b1);
    apply3(25, 18);   check("R8 25-18",   {4'h0, d3}, 16'h0007, nb3, 1'b1);
    apply3(5, 3);     check("R8 5-3",     {4'h0, d3}, 16'h0002, nb3, 1'b1);
  endtask

  task automatic t_shortfall;
    apply3(3, 4);   check("R3 3-4",   {4'h0, d3}, 16'h0999, nb3, 1'b0);
    apply3(0, 1);   check("R3 R7 0-1 ripple", {4'h0, d3}, 16'h0999, nb3, 1'b0);
    apply3(0, 999); check("R3 0-999", {4'h0, d3}, 16'h0001, nb3, 1'b0);
    apply3(258, 741); check("R3 258-741", {4'h0, d3}, 16'h0517, nb3, 1'b0);
  endtask

  task automatic t_equal;
    apply3(999, 999); check("R4 999-999", {4'h0, d3}, 16'h0000, nb3, 1'b1);
    apply3(506, 506); check("R4 506-506", {4'h0, d3}, 16'h0000, nb3, 1'b1);
  endtask

  task automatic t_zero_sub;
    apply3(999, 0); check("R5 999-0", {4'h0, d3}, 16'h0999, nb3, 1'b1);
    apply3(370, 0); check("R5 370-0", {4'h0, d3}, 16'h0370, nb3, 1'b1);
  endtask

  task automatic t_nines_each_digit;
    // R6: subtrahend d in every position, minuend 999 gives digit 9-d
    for (int d = 0; d < 10; d++) begin
      apply3(999, d * 111);
      check("R6 partner", {4'h0, d3}, to_bcd(999 - d * 111), nb3, 1'b1);
    end
  endtask

  task automatic t_sweep2;
    for (int a = 0; a < 100; a++) begin
      for (int b = 0; b < 100; b++) begin
        @(negedge clk);
        x2 = to_bcd(a)[7:0];
        y2 = to_bcd(b)[7:0];
        #1;
        if (a >= b)
          check("R1 R2 sweep", {8'h00, d2}, to_bcd(a - b), nb2, 1'b1);
        else
          check("R1 R3 sweep", {8'h00, d2}, to_bcd(100 - (b - a)), nb2, 1'b0);
      end
    end
  endtask

  initial begin
    t_start_state;
    t_worked_cases;
    t_shortfall;
    t_equal;
    t_zero_sub;
    t_nines_each_digit;
    t_sweep2;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule